// File: doc/BRIEF.md
# Accumulator Datapath with Four-Entry Register File

This block joins a small arithmetic/logic unit to a four-word register file, giving an accumulator-style datapath. Every operation takes its first operand from the register file at the selected address and its second operand from an external 4-bit input. The result is captured in a result register that also drives the Z, N and P condition flags and a carry flag. In write mode the result register is stored back into the chosen register file entry.

A three-state controller sequences each operation. `ST_IDLE` waits for `start`. The `go` transition moves it to `ST_FETCH`. In `ST_FETCH` the block captures the operands and the opcode, performs any memory write, and loads the read display register. The `advance` transition then moves it to `ST_EXEC`, where the ALU result and flags are latched. The `retire` transition returns it to `ST_IDLE`.

There are no move instructions. To copy the last result into memory, issue ADD with a zero external operand in write mode at the target address. To inspect a register without changing it, issue ADD with a zero external operand in read mode at that address.

Top module: `acc_system`

## Requirements
- R1: An active-low asynchronous reset clears the result register, the carry and Z/N/P flags, the read display register and every register file entry to 0, and puts the controller in `ST_IDLE`.
- R2: A `start` sampled high in `ST_IDLE` makes `busy` high for exactly two cycles (`ST_FETCH`, then `ST_EXEC`). The result appears on the clock edge that ends `ST_EXEC`, and `start` is ignored while `busy` is high.
- R3: Opcode 4'b0001 (ADD) makes the result the low 4 bits of operand1 + ext_in + carry_in, with `carry` set to the carry-out of bit 3.
- R4: Opcode 4'b0101 (AND) makes the result operand1 & ext_in, and clears `carry`.
- R5: Opcode 4'b1001 (NOT) makes the result ~operand1, ignores ext_in, and clears `carry`.
- R6: After each recognised operation, `flag_z` = (result == 0), `flag_n` = result bit 3, and `flag_p` = neither. At most one of the three flags is ever high.
- R7: When `wr_mode` is 1 in `ST_FETCH`, the current result register value is written into the entry at `addr`, and that same value is used as operand1. When `wr_mode` is 0, no entry changes.
- R8: When `wr_mode` is 0, `rd_out` loads the entry at `addr` in `ST_FETCH`. When `wr_mode` is 1, `rd_out` keeps its value.
- R9: For ADD with ext_in == 0, the carry-in is forced to 0, so the result equals operand1 exactly and `carry` is 0.
- R10: Any other opcode leaves the result, carry and flags unchanged. The write-mode memory store still takes place.
- R11: While `start` is low in `ST_IDLE`, changes on op, ext_in, addr, wr_mode and carry_in change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| op | input | 4 | Opcode (ADD 0001, AND 0101, NOT 1001) |
| ext_in | input | 4 | External second operand |
| addr | input | 2 | Register file entry used for this operation |
| wr_mode | input | 1 | 1 = store result register at addr, 0 = read addr |
| carry_in | input | 1 | Adder carry-in |
| busy | output | 1 | High in the fetch and execute states |
| result | output | 4 | Result register |
| carry | output | 1 | Carry-out of the last ADD |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result is negative |
| flag_p | output | 1 | Result is positive |
| rd_out | output | 4 | Last value read from the register file |

## Verification
Memory is filled only through the datapath. An ADD in read mode loads a value into the result register, and an ADD of zero in write mode then stores it. Each entry therefore holds a distinct known value, which exposes addressing mistakes.

ADD is tried with and without carry-in, with sums that overflow, and with a zero operand while carry-in is high. The zero-operand case separates the forced pass-through carry from an ordinary add. AND and NOT use masks chosen so that swapped operands or an ignored external input give different results. Results of zero, negative and positive values cover each flag. An unknown opcode in write mode, a `start` held during `busy`, and input changes while idle show what must not move.

// File: rtl/acc_pkg.sv
package acc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } acc_state_e;

    localparam int OPC_W = 4;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fetch_en,
    output logic exec_en,
    output logic busy
);
    acc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;   // go
            ST_FETCH: state_d = ST_EXEC;               // advance
            ST_EXEC:  state_d = ST_IDLE;               // retire
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fetch_en = 1'b0;
        exec_en  = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin fetch_en = 1'b1; busy = 1'b1; end
            ST_EXEC:  begin exec_en  = 1'b1; busy = 1'b1; end
            default:  ;
        endcase
    end

    AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH |=> state_q == ST_EXEC);                  // R2
    AST_EXEC_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EXEC |=> state_q == ST_IDLE);                   // R2
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             valid
);
    logic [W:0]   c;
    logic [W-1:0] sum;

    // pass-through: a zero external operand forces the carry-in low
    assign c[0] = (b == '0) ? 1'b0 : cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    always_comb begin
        res   = '0;
        cout  = 1'b0;
        valid = 1'b1;
        unique case (opc)
            OPC_ADD: begin res = sum; cout = c[W]; end
            OPC_AND: res = a & b;
            OPC_NOT: res = ~a;
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [DEPTH-1:0][W-1:0] mem_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       mem_q[e] <= '0;
            else if (we && addr == AW'(e))    mem_q[e] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q));                                      // R7
endmodule

// File: rtl/acc_system.sv
module acc_system
    import acc_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [W-1:0]  ext_in,
    input  logic [AW-1:0] addr,
    input  logic          wr_mode,
    input  logic          carry_in,
    output logic          busy,
    output logic [W-1:0]  result,
    output logic          carry,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_p,
    output logic [W-1:0]  rd_out
);
    logic fetch_en, exec_en;
    logic [W-1:0] mem_rdata, alu_res;
    logic alu_cout, alu_valid;

    logic [W-1:0]     opa_q, opb_q, dr_q, rd_q;
    logic [OPC_W-1:0] ir_q;
    logic             cin_q, cy_q, z_q, n_q, p_q;

    acc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fetch_en(fetch_en), .exec_en(exec_en), .busy(busy)
    );

    acc_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(fetch_en & wr_mode),
        .addr(addr), .wdata(dr_q), .rdata(mem_rdata)
    );

    acc_alu #(.W(W)) u_alu (
        .opc(ir_q), .a(opa_q), .b(opb_q), .cin(cin_q),
        .res(alu_res), .cout(alu_cout), .valid(alu_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q <= '0; opb_q <= '0; ir_q <= '0; cin_q <= 1'b0; rd_q <= '0;
        end else if (fetch_en) begin
            opa_q <= wr_mode ? dr_q : mem_rdata;
            opb_q <= ext_in;
            ir_q  <= op;
            cin_q <= carry_in;
            if (!wr_mode) rd_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0; cy_q <= 1'b0; z_q <= 1'b0; n_q <= 1'b0; p_q <= 1'b0;
        end else if (exec_en && alu_valid) begin
            dr_q <= alu_res;
            cy_q <= alu_cout;
            z_q  <= (alu_res == '0);
            n_q  <= alu_res[W-1];
            p_q  <= (alu_res != '0) && !alu_res[W-1];
        end
    end

    assign result = dr_q;
    assign carry  = cy_q;
    assign flag_z = z_q;
    assign flag_n = n_q;
    assign flag_p = p_q;
    assign rd_out = rd_q;

    AST_RD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_en && !wr_mode) |=> $stable(rd_out));                 // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_z, flag_n, flag_p}));                          // R6
    AST_PASS_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ir_q == OPC_ADD && opb_q == '0) |=> !carry);      // R9
    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(result));                                // R11
endmodule

// File: tb/sim_acc_system.sv
module sim_acc_system;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = 4'h0, ext_in = 4'h0;
    logic [1:0] addr = 2'd0;
    logic       wr_mode = 1'b0, carry_in = 1'b0;
    logic       busy, carry, flag_z, flag_n, flag_p;
    logic [3:0] result, rd_out;

    int n_checks = 0, n_fail = 0;

    logic [3:0] m_mem [4];
    logic [3:0] m_dr = 0, m_rd = 0;
    logic       m_cy = 0, m_z = 0, m_n = 0, m_p = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_system u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ext_in(ext_in),
        .addr(addr), .wr_mode(wr_mode), .carry_in(carry_in), .busy(busy),
        .result(result), .carry(carry), .flag_z(flag_z), .flag_n(flag_n),
        .flag_p(flag_p), .rd_out(rd_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " result"}, {4'h0, result}, {4'h0, m_dr});
        chk({tag, " carry"},  {7'h0, carry},  {7'h0, m_cy});
        chk({tag, " flags"},  {5'h0, flag_z, flag_n, flag_p}, {5'h0, m_z, m_n, m_p});
        chk({tag, " rd_out"}, {4'h0, rd_out}, {4'h0, m_rd});
    endtask

    task automatic model(input logic [3:0] o, input logic [3:0] e, input logic [1:0] a,
                         input logic w, input logic ci);
        logic [3:0] opa;
        logic [4:0] s;
        logic       ok;
        ok = 1'b1;
        opa = w ? m_dr : m_mem[a];
        if (w) m_mem[a] = m_dr;
        else   m_rd = m_mem[a];
        case (o)
            4'b0001: begin
                s = {1'b0, opa} + {1'b0, e} + {4'b0, (e == 0) ? 1'b0 : ci};
                m_dr = s[3:0]; m_cy = s[4];
            end
            4'b0101: begin m_dr = opa & e; m_cy = 1'b0; end
            4'b1001: begin m_dr = ~opa;    m_cy = 1'b0; end
            default: ok = 1'b0;
        endcase
        if (ok) begin
            m_z = (m_dr == 0); m_n = m_dr[3]; m_p = !m_z && !m_n;
        end
    endtask

    // one complete operation, checking busy in each state and all outputs at the end
    task automatic run_op(input string tag, input logic [3:0] o, input logic [3:0] e,
                          input logic [1:0] a, input logic w, input logic ci);
        @(negedge clk);
        op = o; ext_in = e; addr = a; wr_mode = w; carry_in = ci; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R2 busy fetch"}, {7'h0, busy}, 8'h1);
        @(negedge clk);
        chk({tag, " R2 busy exec"}, {7'h0, busy}, 8'h1);
        @(negedge clk);
        chk({tag, " R2 idle"}, {7'h0, busy}, 8'h0);
        model(o, e, a, w, ci);
        chk_all(tag);
    endtask

    task automatic preload(input logic [1:0] a, input logic [3:0] v);
        // clear the result via NOT-free route: AND with 0 at a zero read, then add v
        run_op("load R3", 4'b0101, 4'h0, a, 1'b0, 1'b0);
        run_op("load R3", 4'b0001, v, a, 1'b0, 1'b0);
        run_op("store R7", 4'b0001, 4'h0, a, 1'b1, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_mem[i] = 4'h0;
        m_dr = 0; m_rd = 0; m_cy = 0; m_z = 0; m_n = 0; m_p = 0;
        chk("R1 busy", {7'h0, busy}, 8'h0);
        chk_all("R1 reset");
    endtask

    task automatic t_fill_and_read;
        preload(2'd0, 4'h3);
        preload(2'd1, 4'hA);
        preload(2'd2, 4'h6);
        preload(2'd3, 4'hF);
        for (int i = 0; i < 4; i++)
            run_op("R8 read pass", 4'b0001, 4'h0, 2'(i), 1'b0, 1'b1);
    endtask

    task automatic t_alu;
        run_op("R3 add", 4'b0001, 4'h4, 2'd0, 1'b0, 1'b0);
        run_op("R3 add cin", 4'b0001, 4'h4, 2'd0, 1'b0, 1'b1);
        run_op("R3 add ovf", 4'b0001, 4'h7, 2'd1, 1'b0, 1'b1);
        run_op("R4 and", 4'b0101, 4'hC, 2'd1, 1'b0, 1'b0);
        run_op("R5 not", 4'b1001, 4'h5, 2'd2, 1'b0, 1'b1);
        run_op("R6 zero", 4'b1001, 4'h0, 2'd3, 1'b0, 1'b0);
        run_op("R6 neg", 4'b0001, 4'h5, 2'd2, 1'b0, 1'b0);
        run_op("R6 pos", 4'b0101, 4'h7, 2'd3, 1'b0, 1'b0);
        run_op("R9 pass", 4'b0001, 4'h0, 2'd3, 1'b0, 1'b1);
    endtask

    task automatic t_writeback;
        // R7: ops in write mode store old result and use it as operand; rd_out holds
        run_op("R7 not wr", 4'b1001, 4'h0, 2'd1, 1'b1, 1'b0);
        run_op("R7 add wr", 4'b0001, 4'h2, 2'd2, 1'b1, 1'b0);
        run_op("R7 back1", 4'b0001, 4'h0, 2'd1, 1'b0, 1'b0);
        run_op("R7 back2", 4'b0001, 4'h0, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_unknown;
        run_op("R10 unk wr", 4'b0011, 4'h9, 2'd0, 1'b1, 1'b1);
        run_op("R10 unk rd", 4'b1111, 4'h9, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_ignore;
        // R2: start held through FETCH does not trigger a second operation
        @(negedge clk);
        op = 4'b1001; ext_in = 4'h0; addr = 2'd1; wr_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        model(4'b1001, 4'h0, 2'd1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R2 no restart busy", {7'h0, busy}, 8'h0);
        chk_all("R2 held start");
        // R11: inputs toggle while idle with start low
        op = 4'b0001; ext_in = 4'hF; addr = 2'd3; wr_mode = 1'b1; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        op = 4'b0101; ext_in = 4'h1; addr = 2'd0; wr_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R11 idle");
        run_op("R11 mem intact", 4'b0001, 4'h0, 2'd3, 1'b0, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fill_and_read();
                t_alu();
                t_writeback();
                t_unknown();
                t_ignore();
                t_reset();
                run_op("R1 mem cleared", 4'b0001, 4'h0, 2'd1, 1'b0, 1'b0);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule